// File: doc/BRIEF.md
# Instruction Cycle Timing Sequencer with Opcode-Substitution Interrupts

This block paces the cycles of a small 8-bit accumulator processor. It counts the cycles of each instruction and drives six active-low timing lines. It marks the opcode-fetch cycle with `sync`, strobes the instruction register load, and holds that register. The instruction decoder reports two things for the instruction currently in the register: its length in cycles and, for conditional branches, whether the branch is taken and whether it crosses a page. The sequencer uses these to decide which cycle is the last one and when to poll for interrupts.

The block has no separate interrupt sequence. A pending interrupt is committed in a polling cycle. The next opcode fetch then loads the break opcode (00) into the instruction register instead of the memory byte, and it suppresses the program-counter increment so that the interrupted address is the one saved. Taken branches that stay within their page finish without a final-cycle marker. They therefore poll early, in their second cycle, so an interrupt that arrives later in such a branch waits until the instruction after the branch has completed. Datapath, stack pushes and vector fetch belong to neighbouring logic.

Top module: `cycle_timing_seq`

## Requirements
- R1: While `rst_n` is low the block shows the fetch state: `tvec` = 011111, `sync` = 1, `ir` = 00, and `clear_ir` and `pc_inc_inhibit` are both 0. Any committed or latched interrupt is discarded.
- R2: `tvec` is active-low. Bit 5 is the fetch line, bit 4 the final-cycle line, and bits 3..0 the second to fifth cycle lines. An instruction of `op_len` = n cycles (3 to 6) shows 011111 in its fetch cycle, then 110111, 111011, 111101 and 111110 in turn. Its last cycle shows 101111 instead.
- R3: A two-cycle instruction (`op_len` = 2; values below 2 count as 2) shows 100111 in its second cycle, and the next cycle is a fetch with 011111.
- R4: With `is_branch` = 1, a branch that is not taken takes two cycles, as in R3. A taken branch that crosses a page shows 110111, 111011 and 101111, and the next fetch shows 011111.
- R5: A taken branch that does not cross a page shows 110111 and then 111011. The next cycle is a fetch with `sync` = 1 and `tvec` = 111111.
- R6: A pending interrupt is polled in a cycle that shows the final-cycle line. Once it is committed, `clear_ir` stays high from the next cycle through the next fetch. That fetch loads 00 into `ir` instead of `mem_data`, and `pc_inc_inhibit` is high during it.
- R7: `ir` changes only at the end of a cycle with `fetch` = 1. `clear_ir` has no effect in other cycles.
- R8: A taken branch that does not cross a page polls only in its second cycle. An NMI edge arriving later in that branch is serviced at the fetch that follows the next instruction.
- R9: An NMI is latched on a falling edge of `nmi_n` and released when its substituted fetch happens. Holding `nmi_n` low does not cause a second service.
- R10: An IRQ is a low level on `irq_n` and is ignored while `irq_mask` = 1. NMI takes priority over IRQ.
- R11: While `rdy` = 0 the cycle state, `tvec`, `sync` and `ir` hold, and `fetch` = `sync` AND `rdy`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rdy | input | 1 | Cycle advance enable; low stalls |
| nmi_n | input | 1 | Non-maskable interrupt, falling edge |
| irq_n | input | 1 | Maskable interrupt request, low level |
| irq_mask | input | 1 | Interrupt-disable flag from the status register |
| mem_data | input | 8 | Byte read during the opcode fetch |
| op_len | input | 3 | Cycle count of the instruction in `ir` (2 to 6) |
| is_branch | input | 1 | Instruction in `ir` is a conditional branch |
| br_taken | input | 1 | Branch condition is true |
| br_page_cross | input | 1 | Branch target lies in another page |
| tvec | output | 6 | Active-low timing lines: fetch, final, then the second to fifth cycle lines |
| sync | output | 1 | Opcode-fetch cycle |
| fetch | output | 1 | Instruction register load strobe |
| clear_ir | output | 1 | Substitute the break opcode at the next fetch |
| pc_inc_inhibit | output | 1 | Hold the program counter during a substituted fetch |
| ir | output | 8 | Instruction register |

## Verification
The assertions rely on the decoder inputs describing the instruction currently in `ir` and on those inputs staying unchanged while `rdy` is low, because the final-cycle line depends on them combinationally. They also rely on `op_len` being 2 to 6 for non-branch instructions. The stimulus is a scripted instruction stream in which each row supplies the class of the instruction already loaded in `ir`, and the stall rows repeat their class unchanged. Interrupt lines change only at the row boundaries that the edge and level rules expect.

// File: rtl/tseq_pkg.sv
package tseq_pkg;
    // Number of per-cycle timing lines after the fetch and final lines.
    localparam int T_LINES  = 4;
    localparam int TV_W     = T_LINES + 2;
    localparam int MAX_LEN  = T_LINES + 2;
    localparam int STEP_W   = $clog2(MAX_LEN);
    localparam int LEN_W    = $clog2(MAX_LEN + 1);
    localparam int OP_W     = 8;
    localparam logic [OP_W-1:0] BRK_OPCODE = '0;
endpackage

// File: rtl/tseq_step_ctrl.sv
module tseq_step_ctrl
    import tseq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rdy,
    input  logic [LEN_W-1:0]  op_len,
    input  logic              is_branch,
    input  logic              br_taken,
    input  logic              br_page_cross,
    output logic [STEP_W-1:0] step,
    output logic              at_fetch,
    output logic              skip_t0,
    output logic              show_final,
    output logic              poll
);
    typedef struct packed {
        logic [STEP_W-1:0] step;
        logic              skip_t0;
    } st_t;

    st_t st_d, st_q;
    logic [LEN_W-1:0] eff_len;
    logic             short_br;
    logic             last;

    always_comb begin
        // Effective length of the instruction now in the register.
        if (is_branch) begin
            if (!br_taken)          eff_len = LEN_W'(2);
            else if (br_page_cross) eff_len = LEN_W'(4);
            else                    eff_len = LEN_W'(3);
        end else if (op_len < LEN_W'(2)) begin
            eff_len = LEN_W'(2);
        end else if (op_len > LEN_W'(MAX_LEN)) begin
            eff_len = LEN_W'(MAX_LEN);
        end else begin
            eff_len = op_len;
        end

        short_br   = is_branch && br_taken && !br_page_cross;
        at_fetch   = (st_q.step == '0);
        last       = !at_fetch && (LEN_W'(st_q.step) == eff_len - LEN_W'(1));
        show_final = last && !short_br;
        // Short taken branches never show a final cycle: poll in their second.
        poll       = short_br ? (st_q.step == STEP_W'(1)) : show_final;

        st_d = st_q;
        if (rdy) begin
            if (last) begin
                st_d.step    = '0;
                st_d.skip_t0 = short_br;
            end else begin
                st_d.step    = st_q.step + STEP_W'(1);
                if (at_fetch) st_d.skip_t0 = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign step    = st_q.step;
    assign skip_t0 = st_q.skip_t0;
endmodule

// File: rtl/tseq_int_ctrl.sv
module tseq_int_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic rdy,
    input  logic nmi_n,
    input  logic irq_n,
    input  logic irq_mask,
    input  logic poll,
    input  logic fetch,
    output logic commit
);
    typedef struct packed {
        logic nmi_prev;
        logic nmi_pend;
        logic commit;
        logic commit_nmi;
    } ist_t;

    ist_t s_d, s_q;
    logic nmi_edge;
    logic irq_req;

    always_comb begin
        s_d      = s_q;
        nmi_edge = s_q.nmi_prev && !nmi_n;
        irq_req  = !irq_n && !irq_mask;
        s_d.nmi_prev = nmi_n;

        // Commit in a polling cycle; NMI wins over IRQ.
        if (poll && rdy && !s_q.commit && (s_q.nmi_pend || irq_req)) begin
            s_d.commit     = 1'b1;
            s_d.commit_nmi = s_q.nmi_pend;
        end

        // The substituted fetch consumes the commitment.
        if (fetch && s_q.commit) begin
            s_d.commit     = 1'b0;
            s_d.commit_nmi = 1'b0;
            if (s_q.commit_nmi) s_d.nmi_pend = 1'b0;
        end

        if (nmi_edge) s_d.nmi_pend = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{nmi_prev: 1'b1, nmi_pend: 1'b0, commit: 1'b0, commit_nmi: 1'b0};
        else        s_q <= s_d;
    end

    assign commit = s_q.commit;
endmodule

// File: rtl/tseq_tvec_enc.sv
module tseq_tvec_enc
    import tseq_pkg::*;
(
    input  logic [STEP_W-1:0] step,
    input  logic              at_fetch,
    input  logic              skip_t0,
    input  logic              show_final,
    output logic [TV_W-1:0]   tvec
);
    assign tvec[TV_W-1] = !(at_fetch && !skip_t0);
    assign tvec[TV_W-2] = !show_final;

    // Line for cycle i+2 is active in step i+1; a final cycle suppresses
    // every line except the second-cycle one.
    for (genvar i = 0; i < T_LINES; i++) begin : g_line
        if (i == 0) begin : g_first
            assign tvec[T_LINES-1-i] = !(step == STEP_W'(i + 1));
        end else begin : g_rest
            assign tvec[T_LINES-1-i] = !((step == STEP_W'(i + 1)) && !show_final);
        end
    end
endmodule

// File: rtl/cycle_timing_seq.sv
module cycle_timing_seq
    import tseq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rdy,
    input  logic             nmi_n,
    input  logic             irq_n,
    input  logic             irq_mask,
    input  logic [OP_W-1:0]  mem_data,
    input  logic [LEN_W-1:0] op_len,
    input  logic             is_branch,
    input  logic             br_taken,
    input  logic             br_page_cross,
    output logic [TV_W-1:0]  tvec,
    output logic             sync,
    output logic             fetch,
    output logic             clear_ir,
    output logic             pc_inc_inhibit,
    output logic [OP_W-1:0]  ir
);
    logic [STEP_W-1:0] step;
    logic at_fetch, skip_t0, show_final, poll, commit;
    logic [OP_W-1:0] ir_d, ir_q;

    tseq_step_ctrl u_step (
        .clk(clk), .rst_n(rst_n), .rdy(rdy), .op_len(op_len),
        .is_branch(is_branch), .br_taken(br_taken), .br_page_cross(br_page_cross),
        .step(step), .at_fetch(at_fetch), .skip_t0(skip_t0),
        .show_final(show_final), .poll(poll)
    );

    tseq_int_ctrl u_int (
        .clk(clk), .rst_n(rst_n), .rdy(rdy), .nmi_n(nmi_n), .irq_n(irq_n),
        .irq_mask(irq_mask), .poll(poll), .fetch(fetch), .commit(commit)
    );

    tseq_tvec_enc u_enc (
        .step(step), .at_fetch(at_fetch), .skip_t0(skip_t0),
        .show_final(show_final), .tvec(tvec)
    );

    assign sync           = at_fetch;
    assign fetch          = at_fetch && rdy;
    assign clear_ir       = commit;
    assign pc_inc_inhibit = at_fetch && commit;

    always_comb begin
        ir_d = ir_q;
        if (fetch) ir_d = clear_ir ? BRK_OPCODE : mem_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ir_q <= BRK_OPCODE;
        else        ir_q <= ir_d;
    end

    assign ir = ir_q;
endmodule

// File: rtl/tseq_checker.sv
module tseq_checker
    import tseq_pkg::*;
(
    input logic            clk,
    input logic            rst_n,
    input logic            rdy,
    input logic [TV_W-1:0] tvec,
    input logic            sync,
    input logic            fetch,
    input logic            clear_ir,
    input logic            pc_inc_inhibit,
    input logic [OP_W-1:0] ir
);
    assert_one_tline_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(~tvec[T_LINES-1:0]) <= 1);

    assert_final_to_fetch_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!tvec[TV_W-2] && rdy) |=> sync);

    assert_fetch_line_sync_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !tvec[TV_W-1] |-> sync);

    assert_inject_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch && clear_ir) |=> (ir == BRK_OPCODE));

    assert_inhibit_scope_R6: assert property (@(posedge clk) disable iff (!rst_n)
        pc_inc_inhibit |-> (sync && clear_ir));

    assert_ir_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !fetch |=> $stable(ir));

    assert_stall_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !rdy |=> ($stable(tvec) && $stable(sync)));
endmodule

bind cycle_timing_seq tseq_checker u_tseq_chk (
    .clk(clk), .rst_n(rst_n), .rdy(rdy), .tvec(tvec), .sync(sync),
    .fetch(fetch), .clear_ir(clear_ir), .pc_inc_inhibit(pc_inc_inhibit), .ir(ir)
);

// File: tb/cycle_timing_seq_bench.sv
module cycle_timing_seq_bench;
    // Row: rdy nmi_n irq_n mask data[8] len[3] br tk cx | tvec[6] sync ir[8] clr inh
    localparam int ROW_W = 35;
    localparam int NROWS = 60;
    localparam logic [ROW_W-1:0] TBL [NROWS] = '{
        // R2 R3: two-cycle then six-cycle
        {4'b1110, 8'hA9, 3'd2, 3'b000, 6'b011111, 1'b1, 8'h00, 2'b00},
        {4'b1110, 8'h00, 3'd2, 3'b000, 6'b100111, 1'b0, 8'hA9, 2'b00},
        {4'b1110, 8'h20, 3'd2, 3'b000, 6'b011111, 1'b1, 8'hA9, 2'b00},
        {4'b1110, 8'h00, 3'd6, 3'b000, 6'b110111, 1'b0, 8'h20, 2'b00},
        {4'b1110, 8'h00, 3'd6, 3'b000, 6'b111011, 1'b0, 8'h20, 2'b00},
        {4'b1110, 8'h00, 3'd6, 3'b000, 6'b111101, 1'b0, 8'h20, 2'b00},
        {4'b1110, 8'h00, 3'd6, 3'b000, 6'b111110, 1'b0, 8'h20, 2'b00},
        {4'b1110, 8'h00, 3'd6, 3'b000, 6'b101111, 1'b0, 8'h20, 2'b00},
        // R2: three-cycle
        {4'b1110, 8'h4C, 3'd2, 3'b000, 6'b011111, 1'b1, 8'h20, 2'b00},
        {4'b1110, 8'h00, 3'd3, 3'b000, 6'b110111, 1'b0, 8'h4C, 2'b00},
        {4'b1110, 8'h00, 3'd3, 3'b000, 6'b101111, 1'b0, 8'h4C, 2'b00},
        // R4: branch not taken
        {4'b1110, 8'hB0, 3'd2, 3'b000, 6'b011111, 1'b1, 8'h4C, 2'b00},
        {4'b1110, 8'h00, 3'd2, 3'b100, 6'b100111, 1'b0, 8'hB0, 2'b00},
        // R5: taken, same page
        {4'b1110, 8'hB0, 3'd2, 3'b000, 6'b011111, 1'b1, 8'hB0, 2'b00},
        {4'b1110, 8'h00, 3'd2, 3'b110, 6'b110111, 1'b0, 8'hB0, 2'b00},
        {4'b1110, 8'h00, 3'd2, 3'b110, 6'b111011, 1'b0, 8'hB0, 2'b00},
        {4'b1110, 8'hA9, 3'd2, 3'b000, 6'b111111, 1'b1, 8'hB0, 2'b00},
        {4'b1110, 8'h00, 3'd2, 3'b000, 6'b100111, 1'b0, 8'hA9, 2'b00},
        // R4: taken, page cross
        {4'b1110, 8'hB0, 3'd2, 3'b000, 6'b011111, 1'b1, 8'hA9, 2'b00},
        {4'b1110, 8'h00, 3'd2, 3'b111, 6'b110111, 1'b0, 8'hB0, 2'b00},
        {4'b1110, 8'h00, 3'd2, 3'b111, 6'b111011, 1'b0, 8'hB0, 2'b00},
        {4'b1110, 8'h00, 3'd2, 3'b111, 6'b101111, 1'b0, 8'hB0, 2'b00},
        {4'b1110, 8'hA9, 3'd2, 3'b000, 6'b011111, 1'b1, 8'hB0, 2'b00},
        {4'b1110, 8'h00, 3'd2, 3'b000, 6'b100111, 1'b0, 8'hA9, 2'b00},
        // R6 R9: NMI in a three-cycle instruction, held low afterwards
        {4'b1110, 8'h4C, 3'd2, 3'b000, 6'b011111, 1'b1, 8'hA9, 2'b00},
        {4'b1010, 8'h00, 3'd3, 3'b000, 6'b110111, 1'b0, 8'h4C, 2'b00},
        {4'b1010, 8'h00, 3'd3, 3'b000, 6'b101111, 1'b0, 8'h4C, 2'b00},
        {4'b1010, 8'hA9, 3'd2, 3'b000, 6'b011111, 1'b1, 8'h4C, 2'b11},
        {4'b1010, 8'h00, 3'd6, 3'b000, 6'b110111, 1'b0, 8'h00, 2'b00},
        {4'b1110, 8'h00, 3'd6, 3'b000, 6'b111011, 1'b0, 8'h00, 2'b00},
        {4'b1110, 8'h00, 3'd6, 3'b000, 6'b111101, 1'b0, 8'h00, 2'b00},
        {4'b1110, 8'h00, 3'd6, 3'b000, 6'b111110, 1'b0, 8'h00, 2'b00},
        {4'b1110, 8'h00, 3'd6, 3'b000, 6'b101111, 1'b0, 8'h00, 2'b00},
        {4'b1110, 8'hA9, 3'd2, 3'b000, 6'b011111, 1'b1, 8'h00, 2'b00},
        {4'b1110, 8'h00, 3'd2, 3'b000, 6'b100111, 1'b0, 8'hA9, 2'b00},
        // R8: late NMI in a short taken branch is deferred one instruction
        {4'b1110, 8'hB0, 3'd2, 3'b000, 6'b011111, 1'b1, 8'hA9, 2'b00},
        {4'b1110, 8'h00, 3'd2, 3'b110, 6'b110111, 1'b0, 8'hB0, 2'b00},
        {4'b1010, 8'h00, 3'd2, 3'b110, 6'b111011, 1'b0, 8'hB0, 2'b00},
        {4'b1010, 8'hA9, 3'd2, 3'b000, 6'b111111, 1'b1, 8'hB0, 2'b00},
        {4'b1010, 8'h00, 3'd2, 3'b000, 6'b100111, 1'b0, 8'hA9, 2'b00},
        {4'b1010, 8'h4C, 3'd2, 3'b000, 6'b011111, 1'b1, 8'hA9, 2'b11},
        {4'b1010, 8'h00, 3'd2, 3'b000, 6'b100111, 1'b0, 8'h00, 2'b00},
        {4'b1010, 8'hA9, 3'd2, 3'b000, 6'b011111, 1'b1, 8'h00, 2'b00},
        {4'b1110, 8'h00, 3'd2, 3'b000, 6'b100111, 1'b0, 8'hA9, 2'b00},
        // R8: early NMI in a short taken branch is taken after it
        {4'b1010, 8'hB0, 3'd2, 3'b000, 6'b011111, 1'b1, 8'hA9, 2'b00},
        {4'b1010, 8'h00, 3'd2, 3'b110, 6'b110111, 1'b0, 8'hB0, 2'b00},
        {4'b1010, 8'h00, 3'd2, 3'b110, 6'b111011, 1'b0, 8'hB0, 2'b10},
        {4'b1010, 8'hA9, 3'd2, 3'b000, 6'b111111, 1'b1, 8'hB0, 2'b11},
        {4'b1110, 8'h00, 3'd2, 3'b000, 6'b100111, 1'b0, 8'h00, 2'b00},
        {4'b1110, 8'hA9, 3'd2, 3'b000, 6'b011111, 1'b1, 8'h00, 2'b00},
        {4'b1110, 8'h00, 3'd2, 3'b000, 6'b100111, 1'b0, 8'hA9, 2'b00},
        // R10: IRQ masked, then unmasked
        {4'b1101, 8'h4C, 3'd2, 3'b000, 6'b011111, 1'b1, 8'hA9, 2'b00},
        {4'b1101, 8'h00, 3'd3, 3'b000, 6'b110111, 1'b0, 8'h4C, 2'b00},
        {4'b1101, 8'h00, 3'd3, 3'b000, 6'b101111, 1'b0, 8'h4C, 2'b00},
        {4'b1101, 8'hA9, 3'd2, 3'b000, 6'b011111, 1'b1, 8'h4C, 2'b00},
        {4'b1100, 8'h00, 3'd2, 3'b000, 6'b100111, 1'b0, 8'hA9, 2'b00},
        {4'b1100, 8'h4C, 3'd2, 3'b000, 6'b011111, 1'b1, 8'hA9, 2'b11},
        {4'b1111, 8'h00, 3'd2, 3'b000, 6'b100111, 1'b0, 8'h00, 2'b00},
        {4'b1111, 8'hA9, 3'd2, 3'b000, 6'b011111, 1'b1, 8'h00, 2'b00},
        {4'b1111, 8'h00, 3'd2, 3'b000, 6'b100111, 1'b0, 8'hA9, 2'b00}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rdy = 1'b0, nmi_n = 1'b1, irq_n = 1'b1, irq_mask = 1'b0;
    logic [7:0] mem_data = 8'h00;
    logic [2:0] op_len = 3'd2;
    logic       is_branch = 1'b0, br_taken = 1'b0, br_page_cross = 1'b0;
    logic [5:0] tvec;
    logic       sync, fetch, clear_ir, pc_inc_inhibit;
    logic [7:0] ir;
    int n_tests = 0, n_fail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    cycle_timing_seq u_cycle_timing_seq (
        .clk(clk), .rst_n(rst_n), .rdy(rdy), .nmi_n(nmi_n), .irq_n(irq_n),
        .irq_mask(irq_mask), .mem_data(mem_data), .op_len(op_len),
        .is_branch(is_branch), .br_taken(br_taken), .br_page_cross(br_page_cross),
        .tvec(tvec), .sync(sync), .fetch(fetch), .clear_ir(clear_ir),
        .pc_inc_inhibit(pc_inc_inhibit), .ir(ir)
    );

    task automatic chk(input string what, input logic [31:0] got, input logic [31:0] exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", what, got, exp);
        end
    endtask

    // Drive one row at the falling edge, check just after.
    task automatic run_row(input string tag, input logic [ROW_W-1:0] r);
        @(negedge clk);
        {rdy, nmi_n, irq_n, irq_mask} = r[34:31];
        mem_data  = r[30:23];
        op_len    = r[22:20];
        {is_branch, br_taken, br_page_cross} = r[19:17];
        #2;
        chk({tag, " tvec"},  32'(tvec), 32'(r[16:11]));
        chk({tag, " sync"},  32'(sync), 32'(r[10]));
        chk({tag, " ir"},    32'(ir),   32'(r[9:2]));
        chk({tag, " clear_ir"}, 32'(clear_ir), 32'(r[1]));
        chk({tag, " pc_inc_inhibit"}, 32'(pc_inc_inhibit), 32'(r[0]));
        chk({tag, " fetch R11"}, 32'(fetch), 32'(r[10] & r[34]));
    endtask

    task automatic reset_check(input string tag);
        chk({tag, " R1 tvec"}, 32'(tvec), 32'(6'b011111));
        chk({tag, " R1 sync"}, 32'(sync), 32'd1);
        chk({tag, " R1 ir"},   32'(ir),   32'h00);
        chk({tag, " R1 clear_ir"}, 32'(clear_ir), 32'd0);
        chk({tag, " R1 pc_inc_inhibit"}, 32'(pc_inc_inhibit), 32'd0);
    endtask

    initial begin
        #2;
        reset_check("power-on");
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // Scripted stream covering R2 to R10
        for (int i = 0; i < NROWS; i++) begin
            run_row($sformatf("table row %0d", i), TBL[i]);
        end

        // R11: stall mid-instruction and at a fetch
        run_row("R11 fetch", {4'b1110, 8'h4C, 3'd2, 3'b000, 6'b011111, 1'b1, 8'hA9, 2'b00});
        run_row("R11 stall a", {4'b0110, 8'h00, 3'd3, 3'b000, 6'b110111, 1'b0, 8'h4C, 2'b00});
        run_row("R11 stall b", {4'b0110, 8'h00, 3'd3, 3'b000, 6'b110111, 1'b0, 8'h4C, 2'b00});
        run_row("R11 resume", {4'b1110, 8'h00, 3'd3, 3'b000, 6'b110111, 1'b0, 8'h4C, 2'b00});
        run_row("R11 final", {4'b1110, 8'h00, 3'd3, 3'b000, 6'b101111, 1'b0, 8'h4C, 2'b00});
        run_row("R11 fetch stall", {4'b0110, 8'hA9, 3'd2, 3'b000, 6'b011111, 1'b1, 8'h4C, 2'b00});
        run_row("R11 fetch go", {4'b1110, 8'hA9, 3'd2, 3'b000, 6'b011111, 1'b1, 8'h4C, 2'b00});
        run_row("R11 after", {4'b1110, 8'h00, 3'd2, 3'b000, 6'b100111, 1'b0, 8'hA9, 2'b00});

        // R1: reset while an NMI is committed discards it
        run_row("R1 pre a", {4'b1110, 8'h4C, 3'd2, 3'b000, 6'b011111, 1'b1, 8'hA9, 2'b00});
        run_row("R1 pre b", {4'b1010, 8'h00, 3'd3, 3'b000, 6'b110111, 1'b0, 8'h4C, 2'b00});
        run_row("R1 pre c", {4'b1010, 8'h00, 3'd3, 3'b000, 6'b101111, 1'b0, 8'h4C, 2'b00});
        @(negedge clk);
        rst_n = 1'b0; rdy = 1'b0; nmi_n = 1'b1;
        #2;
        reset_check("mid-run");
        @(negedge clk);
        rst_n = 1'b1;
        run_row("R1 post a", {4'b1110, 8'hA9, 3'd2, 3'b000, 6'b011111, 1'b1, 8'h00, 2'b00});
        run_row("R1 post b", {4'b1110, 8'h00, 3'd2, 3'b000, 6'b100111, 1'b0, 8'hA9, 2'b00});
        run_row("R1 post c", {4'b1110, 8'hA9, 3'd2, 3'b000, 6'b011111, 1'b1, 8'hA9, 2'b00});

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #(20 * 5000);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule